// File: doc/BRIEF.md
# Edge-Selectable External Event Counter

This block counts pulses that arrive on an asynchronous external pin, using a faster system clock to sample that pin. The pin is first passed through a synchroniser. Edges are then found by comparing the newest synchronised sample with the one before it. A single select input decides which polarity advances the count: rising edges or falling edges.

An 8-bit compare value sets the terminal count. When a counted edge brings the counter to that value, the block raises a one-clock interrupt request. The next counted edge then loads zero, so the count runs 0x00, 0x01, ... N, 0x00, ... and the interrupt repeats at every match. A count-enable input starts and stops the block. While it is low, the counter rests at zero and no interrupt is raised.

Top module: `edge_event_counter`

## Requirements
- R1: After reset the count output is 0x00 and the interrupt output is 0.
- R2: With edgeRise = 1, every rising edge of evtPin adds one to the count, and falling edges leave the count unchanged.
- R3: With edgeRise = 0, every falling edge of evtPin adds one to the count, and rising edges leave the count unchanged.
- R4: When a counted edge makes the count equal to cmpVal, irq is high for exactly one clock, in the same cycle the new count first appears.
- R5: The counted edge that follows a match loads 0x00 instead of incrementing. The sequence 0x00 to N then repeats, with one irq pulse per match.
- R6: With cmpVal = 0x00, every counted edge raises irq and the count stays at 0x00.
- R7: With cmpVal = 0xFF, the count passes through every value up to 0xFF, raises irq there, and returns to 0x00 on the following edge.
- R8: While countEn is 0, the count is held at 0x00 and irq stays low whatever evtPin does. After countEn returns to 1, counting restarts from 0x00.
- R9: Between two clocks the count either stays the same, rises by exactly one, or becomes 0x00.
- R10: Each pin level must be held for at least two clock periods. Every edge that meets this rule is counted once, and the count changes on the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| evtPin | input | 1 | Asynchronous external event input |
| edgeRise | input | 1 | 1 counts rising edges, 0 counts falling edges |
| countEn | input | 1 | Count enable; low holds the count at zero |
| cmpVal | input | 8 | Terminal count compared against the counter |
| count | output | 8 | Current count value |
| irq | output | 1 | One-clock interrupt request raised on a match |

## Verification
The assertions check four properties on every clock:
- irq is never wider than one cycle.
- irq is only raised when the count equals the previous cycle's compare value.
- irq only appears after an enabled cycle.
- The count only steps by one or falls to zero, and is zero after any disabled cycle.

Only the bench scenarios can show the rest: that the correct polarity is counted, that edges of the other polarity are ignored, the exact wrap sequences at compare values 0x00, 0x03 and 0xFF, and the restart from zero after re-enabling.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Strobes issued by the control to the counting datapath
  typedef struct packed {
    logic hold;   // enable low: force count to zero
    logic step;   // a qualified edge was seen this cycle
    logic wrap;   // the count is at the terminal value: load zero on step
  } evc_strobe_t;

endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        evtIn,
  input  logic        edgeRise,
  input  logic        enable,
  input  logic        atMatch,
  input  logic        nextHit,
  output evc_strobe_t strobe,
  output logic        irq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic sampled;
  logic riseSeen;
  logic fallSeen;
  logic validEdge;

  // Synchroniser chain, stage 0 samples the pin
  always_ff @(posedge clk) begin
    if (rst) syncQ[0] <= 1'b0;
    else     syncQ[0] <= evtIn;
  end

  genvar gi;
  generate
    for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) syncQ[gi] <= 1'b0;
        else     syncQ[gi] <= syncQ[gi-1];
      end
    end
  endgenerate

  assign sampled = syncQ[LAST];

  // Edge history
  always_ff @(posedge clk) begin
    if (rst) prevQ <= 1'b0;
    else     prevQ <= sampled;
  end

  assign riseSeen  = sampled & ~prevQ;
  assign fallSeen  = ~sampled & prevQ;
  assign validEdge = edgeRise ? riseSeen : fallSeen;

  always_comb begin
    strobe.hold = ~enable;
    strobe.step = enable & validEdge;
    strobe.wrap = atMatch;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= strobe.step & nextHit;
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(enable)); // R8

endmodule

// File: rtl/evc_datapath.sv
module evc_datapath
  import evc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  evc_strobe_t      strobe,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] count,
  output logic             atMatch,
  output logic             nextHit
);

  logic [CNT_W-1:0] nextVal;

  assign atMatch = (count == cmpVal);
  assign nextVal = strobe.wrap ? '0 : count + 1'b1;
  assign nextHit = (nextVal == cmpVal);

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (strobe.hold) count <= '0;
    else if (strobe.step) count <= nextVal;
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + 1'b1 || count == '0)); // R9

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe.hold |=> (count == '0)); // R8

endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import evc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evtPin,
  input  logic             edgeRise,
  input  logic             countEn,
  input  logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] count,
  output logic             irq
);

  evc_strobe_t strobe;
  logic atMatch;
  logic nextHit;

  evc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .evtIn    (evtPin),
    .edgeRise (edgeRise),
    .enable   (countEn),
    .atMatch  (atMatch),
    .nextHit  (nextHit),
    .strobe   (strobe),
    .irq      (irq)
  );

  evc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .cmpVal  (cmpVal),
    .count   (count),
    .atMatch (atMatch),
    .nextHit (nextHit)
  );

  AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq |-> (count == $past(cmpVal))); // R4

endmodule

// File: tb/edge_event_counter_bench.sv
module edge_event_counter_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       evtPin = 1'b0;
  logic       edgeRise = 1'b1;
  logic       countEn = 1'b0;
  logic [7:0] cmpVal = 8'd200;
  logic [7:0] count;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  int irqTotal = 0;
  int wideIrq = 0;
  logic irqPrev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_event_counter u_edge_event_counter (
    .clk(clk), .rst(rst), .evtPin(evtPin), .edgeRise(edgeRise),
    .countEn(countEn), .cmpVal(cmpVal), .count(count), .irq(irq)
  );

  always @(posedge clk) begin
    if (irq === 1'b1) irqTotal++;
    if (irq === 1'b1 && irqPrev === 1'b1) wideIrq++;
    irqPrev <= irq;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(input logic v);
    evtPin = v;
    idle(4);
  endtask

  task automatic pulse();
    setPin(1'b1);
    setPin(1'b0);
  endtask

  task automatic restart();
    countEn = 1'b0;
    idle(3);
    countEn = 1'b1;
    idle(1);
  endtask

  task automatic test_reset();
    idle(3);
    check("R1 count", count, 0);
    check("R1 irq", irq, 0);
    rst = 1'b0;
    idle(2);
  endtask

  task automatic test_rising();
    edgeRise = 1'b1; cmpVal = 8'd200; restart();
    setPin(1'b1);
    check("R2 rise counted", count, 1);
    setPin(1'b0);
    check("R2 fall ignored", count, 1);
    for (int i = 0; i < 4; i++) pulse();
    check("R2 five rising", count, 5);
  endtask

  task automatic test_latency();
    int base;
    edgeRise = 1'b1; cmpVal = 8'd200; restart();
    base = count;
    @(negedge clk); evtPin = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 not before third edge", count, base);
    @(negedge clk);
    check("R10 on third edge", count, base + 1);
    idle(2);
    evtPin = 1'b0;
    idle(2);
    evtPin = 1'b1;
    idle(4);
    check("R10 two-cycle levels", count, base + 2);
    setPin(1'b0);
  endtask

  task automatic test_falling();
    edgeRise = 1'b0; cmpVal = 8'd200; restart();
    setPin(1'b1);
    check("R3 rise ignored", count, 0);
    setPin(1'b0);
    check("R3 fall counted", count, 1);
    for (int i = 0; i < 3; i++) pulse();
    check("R3 four falling", count, 4);
    edgeRise = 1'b1;
  endtask

  task automatic test_match();
    int startIrq;
    int expSeq [8] = '{1, 2, 3, 0, 1, 2, 3, 0};
    edgeRise = 1'b1; cmpVal = 8'd3; restart();
    startIrq = irqTotal;
    for (int i = 0; i < 8; i++) begin
      pulse();
      check("R5 sequence", count, expSeq[i]);
      if (i == 2) check("R4 first irq", irqTotal - startIrq, 1);
    end
    check("R5 irq per match", irqTotal - startIrq, 2);
    check("R4 irq width", wideIrq, 0);
  endtask

  task automatic test_cmp_zero();
    int startIrq;
    cmpVal = 8'd0; restart();
    startIrq = irqTotal;
    for (int i = 0; i < 4; i++) pulse();
    check("R6 count stays zero", count, 0);
    check("R6 irq each edge", irqTotal - startIrq, 4);
  endtask

  task automatic test_cmp_max();
    int startIrq;
    cmpVal = 8'hFF; restart();
    startIrq = irqTotal;
    for (int i = 0; i < 255; i++) pulse();
    check("R7 reaches FF", count, 255);
    check("R7 irq at FF", irqTotal - startIrq, 1);
    pulse();
    check("R7 back to zero", count, 0);
    check("R7 single irq", irqTotal - startIrq, 1);
  endtask

  task automatic test_disable();
    int startIrq;
    cmpVal = 8'd10; restart();
    for (int i = 0; i < 3; i++) pulse();
    check("R8 counted before disable", count, 3);
    countEn = 1'b0;
    idle(2);
    check("R8 held zero", count, 0);
    cmpVal = 8'd0;
    startIrq = irqTotal;
    for (int i = 0; i < 3; i++) pulse();
    check("R8 edges ignored", count, 0);
    check("R8 no irq disabled", irqTotal - startIrq, 0);
    cmpVal = 8'd10;
    countEn = 1'b1;
    idle(1);
    pulse();
    check("R8 restart from zero", count, 1);
  endtask

  initial begin
    idle(1);
    test_reset();
    test_rising();
    test_latency();
    test_falling();
    test_match();
    test_cmp_zero();
    test_cmp_max();
    test_disable();
    check("R4 irq never wide", wideIrq, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule